// File: doc/BRIEF.md
# Transparent Serial Channel Synchronizer

This block sits between a bit-serial line and a byte-wide core. It decides the exact bit at which received data starts and the exact bit at which transmitted data starts; between those points it carries raw bits with no framing, flags or stuffing. The receiver hunts for a start condition. Depending on the configured method, that condition is an in-line sync pattern of 8 or 16 bits, an external start strobe, or nothing at all, in which case the first bit seen is data. Once locked, the receiver packs every following bit into bytes and presents them on a valid/ready output.

The transmitter holds its line at idle ones until its own start condition is met. In pattern mode it first shifts out the configured pattern and then data follows with no gap. In external mode it waits for a clear-to-send input. In automatic mode it starts at once. Data bytes come from a valid/ready input. When no byte is offered at a byte boundary, an all-ones byte goes out and an underrun pulse is raised.

Bit timing comes from a bit-enable strobe. A reverse option makes every byte on the line, pattern bytes included, travel least significant bit first.

Top module: `transparent_sync`

## Requirements
- R1: After synchronous reset `rx_valid`, `tx_ready` and `tx_underrun` are 0 and `tx_bit` is 1.
- R2: Pattern mode with `cfg_len`=1 (8-bit pattern, `cfg_pattern[7:0]`): the receiver locks on the bit that completes the pattern, and the very next bit is bit one of the first data byte. No byte is delivered from bits at or before the pattern.
- R3: Pattern mode with `cfg_len`=2 (16-bit pattern): the byte in `cfg_pattern[15:8]` must arrive first and the byte in `cfg_pattern[7:0]` second. Lock and first data bit follow as in R2.
- R4: External mode (`cfg_mode`=1): the receive bit sampled while `rx_strobe` is high is the first data bit, and in-line pattern bits before it are ignored. The transmitter sends idle ones and takes no byte until `tx_cts` is high, then sends data from the next bit.
- R5: Automatic mode (`cfg_mode`=2 or 3): the first bit sampled after `rx_en` rises is data bit one. The transmitter takes its first byte on the first bit slot after `tx_en` rises.
- R6: Pattern mode with `cfg_len`=0 behaves as automatic mode on both directions.
- R7: With `cfg_rev`=0 each byte travels MSB first; with `cfg_rev`=1 it travels LSB first. This applies to received data, transmitted data and each pattern byte.
- R8: In pattern mode the transmitter first sends the pattern (first byte first, per R3, or the single 8-bit byte) and follows it at once with the first data byte.
- R9: If no byte is offered at a transmit byte boundary, the transmitter sends eight ones and pulses `tx_underrun` for that boundary.
- R10: Once locked, the receiver stays locked: later bits equal to the pattern are received as data. A pulse on `rx_resync`, or `rx_en` low, drops the lock and the receiver hunts again.
- R11: A received byte stays on `rx_byte` with `rx_valid` high until `rx_ready` is high. A newer byte that completes in the meantime replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One line bit per cycle in which this is high |
| cfg_mode | input | 2 | Sync method: 0 pattern, 1 external, 2/3 automatic |
| cfg_len | input | 2 | Pattern length: 0 none, 1 eight bits, 2/3 sixteen bits |
| cfg_pattern | input | 16 | Sync pattern; bits 15:8 first byte, 7:0 second (or only) byte |
| cfg_rev | input | 1 | 1 = LSB-first bit order on the line |
| rx_en | input | 1 | Receiver enable; low returns it to hunting |
| rx_bit | input | 1 | Serial receive data |
| rx_strobe | input | 1 | External start strobe for the receiver |
| rx_resync | input | 1 | Drops receive lock |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte pending |
| rx_ready | input | 1 | Consumer accepts the pending byte |
| tx_en | input | 1 | Transmitter enable; low returns it to waiting |
| tx_cts | input | 1 | Clear-to-send for external mode |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | The offered byte is taken at this bit slot |
| tx_underrun | output | 1 | Byte boundary with nothing offered |
| tx_bit | output | 1 | Serial transmit data |

## Verification
The hardest receive case is a false lock or an early byte, where a window that straddles idle bits and the start of the pattern happens to match. The stimulus uses patterns whose first line bit is 1 in both bit orders and precedes them with zeros, so any early match, any byte leaked before lock, or any off-by-one at the first data bit changes the byte count or the byte values. The lock-holding and resync paths are reached by sending a data byte equal to the pattern after lock, then pulsing resync and sending a data byte with no pattern before it: that byte must not appear.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

    localparam int BYTE_W = 8;
    localparam int PAT_W  = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(PAT_W) + 1;
    localparam int BIT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        MODE_PATTERN  = 2'd0,
        MODE_EXTERNAL = 2'd1,
        MODE_AUTO     = 2'd2,
        MODE_AUTO_ALT = 2'd3
    } sync_mode_e;

    typedef enum logic [1:0] {
        PLEN_NONE   = 2'd0,
        PLEN_8      = 2'd1,
        PLEN_16     = 2'd2,
        PLEN_16_ALT = 2'd3
    } pat_len_e;

    typedef enum logic [1:0] {
        TX_WAIT     = 2'd0,
        TX_PREAMBLE = 2'd1,
        TX_DATA     = 2'd2
    } tx_state_e;

    typedef struct packed {
        sync_mode_e        mode;
        pat_len_e          plen;
        logic [PAT_W-1:0]  pattern;
        logic              rev;
    } sync_cfg_t;

    function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

    // Byte rearranged so that its bit 7 is the first bit on the line.
    function automatic logic [BYTE_W-1:0] line_order(input logic [BYTE_W-1:0] b,
                                                     input logic rev);
        return rev ? flip_byte(b) : b;
    endfunction

    function automatic logic immediate_start(input sync_cfg_t c);
        return (c.mode == MODE_AUTO) || (c.mode == MODE_AUTO_ALT) ||
               ((c.mode == MODE_PATTERN) && (c.plen == PLEN_NONE));
    endfunction

    function automatic logic pattern_active(input sync_cfg_t c);
        return (c.mode == MODE_PATTERN) && (c.plen != PLEN_NONE);
    endfunction

    function automatic logic [CNT_W-1:0] pattern_bits(input sync_cfg_t c);
        return (c.plen == PLEN_8) ? CNT_W'(BYTE_W) : CNT_W'(PAT_W);
    endfunction

    // Pattern in line order, first line bit in the MSB; an 8-bit pattern
    // is placed in the upper byte.
    function automatic logic [PAT_W-1:0] pattern_seq(input sync_cfg_t c);
        if (c.plen == PLEN_8)
            return {line_order(c.pattern[BYTE_W-1:0], c.rev), {BYTE_W{1'b1}}};
        return {line_order(c.pattern[PAT_W-1:BYTE_W], c.rev),
                line_order(c.pattern[BYTE_W-1:0], c.rev)};
    endfunction

endpackage

// File: rtl/tsync_rx.sv
module tsync_rx
    import tsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              en,
    input  sync_cfg_t         cfg,
    input  logic              din,
    input  logic              ext_strobe,
    input  logic              resync,
    output logic [BYTE_W-1:0] byte_out,
    output logic              valid,
    input  logic              ready,
    output logic              locked
);

    logic [PAT_W-2:0]  hist;
    logic [CNT_W-1:0]  seen;
    logic              locked_q;
    logic [BYTE_W-2:0] acc;
    logic [BIT_W-1:0]  nbit;
    logic              valid_q;
    logic [BYTE_W-1:0] byte_q;

    logic [PAT_W-1:0]  win;
    logic [PAT_W-1:0]  seq;
    logic              pat_hit;
    logic              start_now;
    logic              take;
    logic              done;
    logic [BYTE_W-1:0] next_acc;

    always_comb begin
        win       = {hist, din};
        seq       = pattern_seq(cfg);
        pat_hit   = 1'b0;
        if (pattern_active(cfg) && !locked_q && (seen >= pattern_bits(cfg) - 1'b1)) begin
            if (cfg.plen == PLEN_8)
                pat_hit = (win[BYTE_W-1:0] == seq[PAT_W-1:BYTE_W]);
            else
                pat_hit = (win == seq);
        end
        start_now = !locked_q &&
                    (immediate_start(cfg) || ((cfg.mode == MODE_EXTERNAL) && ext_strobe));
        take      = locked_q || start_now;
        next_acc  = {acc, din};
        done      = take && (nbit == BIT_W'(BYTE_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist     <= '0;
            seen     <= '0;
            locked_q <= 1'b0;
            acc      <= '0;
            nbit     <= '0;
            valid_q  <= 1'b0;
            byte_q   <= '0;
        end else begin
            if (valid_q && ready) valid_q <= 1'b0;
            if (!en || resync) begin
                locked_q <= 1'b0;
                seen     <= '0;
                nbit     <= '0;
            end else if (bit_en) begin
                hist <= win[PAT_W-2:0];
                if (seen != CNT_W'(PAT_W)) seen <= seen + 1'b1;
                if (pat_hit) locked_q <= 1'b1;
                if (take) begin
                    locked_q <= 1'b1;
                    acc      <= next_acc[BYTE_W-2:0];
                    nbit     <= nbit + 1'b1;
                    if (done) begin
                        valid_q <= 1'b1;
                        byte_q  <= line_order(next_acc, cfg.rev);
                    end
                end
            end
        end
    end

    assign byte_out = byte_q;
    assign valid    = valid_q;
    assign locked   = locked_q;

endmodule

// File: rtl/tsync_tx.sv
module tsync_tx
    import tsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              en,
    input  sync_cfg_t         cfg,
    input  logic              cts,
    input  logic [BYTE_W-1:0] data,
    input  logic              valid,
    output logic              ready,
    output logic              underrun,
    output logic              dout,
    output logic              active
);

    tx_state_e         st;
    logic [BIT_W-1:0]  bcnt;
    logic [CNT_W-1:0]  pcnt;
    logic [PAT_W-1:0]  psr;
    logic [BYTE_W-1:0] dsr;
    logic              dout_q;

    logic              go_now;
    logic              boundary;
    logic [BYTE_W-1:0] ord;
    logic [PAT_W-1:0]  seq;

    always_comb begin
        go_now   = immediate_start(cfg) || ((cfg.mode == MODE_EXTERNAL) && cts);
        boundary = bit_en && en &&
                   (((st == TX_DATA) && (bcnt == '0)) ||
                    ((st == TX_WAIT) && go_now) ||
                    ((st == TX_PREAMBLE) && (pcnt == pattern_bits(cfg))));
        ord      = line_order(data, cfg.rev);
        seq      = pattern_seq(cfg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= TX_WAIT;
            bcnt   <= '0;
            pcnt   <= '0;
            psr    <= '1;
            dsr    <= '1;
            dout_q <= 1'b1;
        end else if (!en) begin
            st     <= TX_WAIT;
            dout_q <= 1'b1;
        end else if (bit_en) begin
            if (boundary) begin
                st   <= TX_DATA;
                bcnt <= BIT_W'(1);
                if (valid) begin
                    dout_q <= ord[BYTE_W-1];
                    dsr    <= {ord[BYTE_W-2:0], 1'b1};
                end else begin
                    dout_q <= 1'b1;
                    dsr    <= '1;
                end
            end else begin
                case (st)
                    TX_WAIT: begin
                        if (pattern_active(cfg)) begin
                            st     <= TX_PREAMBLE;
                            dout_q <= seq[PAT_W-1];
                            psr    <= {seq[PAT_W-2:0], 1'b1};
                            pcnt   <= CNT_W'(1);
                        end else begin
                            dout_q <= 1'b1;
                        end
                    end
                    TX_PREAMBLE: begin
                        dout_q <= psr[PAT_W-1];
                        psr    <= {psr[PAT_W-2:0], 1'b1};
                        pcnt   <= pcnt + 1'b1;
                    end
                    default: begin
                        dout_q <= dsr[BYTE_W-1];
                        dsr    <= {dsr[BYTE_W-2:0], 1'b1};
                        bcnt   <= bcnt + 1'b1;
                    end
                endcase
            end
        end
    end

    assign ready    = boundary;
    assign underrun = boundary && !valid;
    assign dout     = dout_q;
    assign active   = (st != TX_WAIT);

endmodule

// File: rtl/transparent_sync.sv
module transparent_sync
    import tsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_len,
    input  logic [PAT_W-1:0]  cfg_pattern,
    input  logic              cfg_rev,
    input  logic              rx_en,
    input  logic              rx_bit,
    input  logic              rx_strobe,
    input  logic              rx_resync,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic              tx_en,
    input  logic              tx_cts,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_underrun,
    output logic              tx_bit
);

    sync_cfg_t cfg;
    logic      rx_locked;
    logic      tx_active;

    always_comb begin
        cfg.mode    = sync_mode_e'(cfg_mode);
        cfg.plen    = pat_len_e'(cfg_len);
        cfg.pattern = cfg_pattern;
        cfg.rev     = cfg_rev;
    end

    tsync_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .en         (rx_en),
        .cfg        (cfg),
        .din        (rx_bit),
        .ext_strobe (rx_strobe),
        .resync     (rx_resync),
        .byte_out   (rx_byte),
        .valid      (rx_valid),
        .ready      (rx_ready),
        .locked     (rx_locked)
    );

    tsync_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .en       (tx_en),
        .cfg      (cfg),
        .cts      (tx_cts),
        .data     (tx_data),
        .valid    (tx_valid),
        .ready    (tx_ready),
        .underrun (tx_underrun),
        .dout     (tx_bit),
        .active   (tx_active)
    );

endmodule

// File: rtl/tsync_chk.sv
module tsync_chk (
    input logic clk,
    input logic rst,
    input logic rx_valid,
    input logic rx_ready,
    input logic rx_resync,
    input logic rx_locked,
    input logic tx_ready,
    input logic tx_underrun,
    input logic tx_bit,
    input logic tx_active
);

    // A byte can only appear after the receiver has been locked.
    assert_byte_after_lock_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(rx_locked));

    // A pending byte is not dropped while the consumer holds back.
    assert_rx_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> rx_valid);

    // A resync pulse removes the lock.
    assert_resync_unlocks_R10: assert property (@(posedge clk) disable iff (rst)
        rx_resync |=> !rx_locked);

    // A transmitter that has not yet synchronized drives idle ones.
    assert_wait_idle_ones_R4: assert property (@(posedge clk) disable iff (rst)
        !tx_active |-> tx_bit);

    // An underrun boundary is followed by an idle one on the line.
    assert_underrun_ones_R9: assert property (@(posedge clk) disable iff (rst)
        tx_underrun |=> tx_bit);

    // Taking a byte leaves the transmitter in its active state.
    assert_take_activates_R5: assert property (@(posedge clk) disable iff (rst)
        tx_ready |=> tx_active);

endmodule

bind transparent_sync tsync_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_resync   (rx_resync),
    .rx_locked   (rx_locked),
    .tx_ready    (tx_ready),
    .tx_underrun (tx_underrun),
    .tx_bit      (tx_bit),
    .tx_active   (tx_active)
);

// File: tb/sim_transparent_sync.sv
`timescale 1ns/1ps
module sim_transparent_sync;

    localparam logic [15:0] PAT = 16'hB58D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b1;
    logic [1:0]  cfg_mode = 2'd0;
    logic [1:0]  cfg_len = 2'd0;
    logic [15:0] cfg_pattern = PAT;
    logic        cfg_rev = 1'b0;
    logic        rx_en = 1'b0;
    logic        rx_bit = 1'b0;
    logic        rx_strobe = 1'b0;
    logic        rx_resync = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic        rx_ready = 1'b1;
    logic        tx_en = 1'b0;
    logic        tx_cts = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        tx_underrun;
    logic        tx_bit;

    always #2 clk = ~clk;

    transparent_sync u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en),
        .cfg_mode(cfg_mode), .cfg_len(cfg_len), .cfg_pattern(cfg_pattern), .cfg_rev(cfg_rev),
        .rx_en(rx_en), .rx_bit(rx_bit), .rx_strobe(rx_strobe), .rx_resync(rx_resync),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_en(tx_en), .tx_cts(tx_cts), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_underrun(tx_underrun), .tx_bit(tx_bit)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 0;
    logic        bits [0:255];
    int          nb;
    logic [7:0]  got [0:15];
    int          gcnt;
    bit          mon_on = 0;
    logic [7:0]  dat [0:7];

    always @(negedge clk) begin
        if (mon_on && rx_valid && rx_ready) begin
            if (gcnt < 16) got[gcnt] = rx_byte;
            gcnt = gcnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dval(input int seed, input int k);
        return 8'(seed * 53 + k * 91 + 17);
    endfunction

    task automatic push_const(input logic v, input int n);
        for (int i = 0; i < n; i++) begin bits[nb] = v; nb++; end
    endtask

    task automatic push_byte(input logic [7:0] b, input logic rev);
        for (int i = 0; i < 8; i++) begin
            bits[nb] = rev ? b[i] : b[7-i];
            nb++;
        end
    endtask

    task automatic push_pattern(input int len, input logic rev);
        if (len == 1) push_byte(PAT[7:0], rev);
        else begin push_byte(PAT[15:8], rev); push_byte(PAT[7:0], rev); end
    endtask

    task automatic do_reset();
        rx_en = 0; tx_en = 0; tx_valid = 0; tx_cts = 0; rx_strobe = 0; rx_resync = 0;
        rx_ready = 1; rx_bit = 0;
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    // Drive bits[0:nb-1]; strobe on index st_idx, resync on index rs_idx.
    task automatic drive_rx(input int st_idx, input int rs_idx);
        gcnt = 0;
        mon_on = 1;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            rx_en = 1;
            rx_bit = bits[i];
            rx_strobe = (i == st_idx);
            rx_resync = (i == rs_idx);
        end
        @(negedge clk);
        rx_strobe = 0; rx_resync = 0; rx_bit = 0;
        repeat (3) @(negedge clk);
        mon_on = 0;
        rx_en = 0;
    endtask

    task automatic rx_run(input int mode, input int len, input logic rev, input int seed,
                          input string req);
        int st_idx;
        do_reset();
        cfg_mode = 2'(mode); cfg_len = 2'(len); cfg_rev = rev;
        nb = 0; st_idx = -1;
        if (mode == 0 && len != 0) begin
            push_const(1'b0, 6);
            push_pattern(len, rev);
        end else if (mode == 1) begin
            push_const(1'b0, 4);
            push_pattern(2, rev);
            push_const(1'b0, 3);
            st_idx = nb;
        end
        for (int k = 0; k < 3; k++) begin
            dat[k] = dval(seed, k);
            push_byte(dat[k], rev);
        end
        push_const(1'b0, 2);
        drive_rx(st_idx, -1);
        check(gcnt == 3, req, gcnt, 3);
        for (int k = 0; k < 3; k++)
            check(got[k] == dat[k], req, got[k], dat[k]);
    endtask

    task automatic tx_run(input int mode, input int len, input logic rev, input int delay,
                          input int seed, input string req);
        int idx;
        int ucnt;
        int bad_at;
        int total;
        logic rdy;
        logic cap [0:255];
        do_reset();
        cfg_mode = 2'(mode); cfg_len = 2'(len); cfg_rev = rev;
        nb = 0;
        if (mode == 1) push_const(1'b1, delay);
        if (mode == 0 && len != 0) push_pattern(len, rev);
        for (int k = 0; k < 3; k++) begin
            dat[k] = dval(seed, k);
            push_byte(dat[k], rev);
        end
        push_const(1'b1, 8);
        total = nb;
        idx = 0; ucnt = 0;
        tx_data = dat[0]; tx_valid = 1;
        tx_cts = (mode == 1 && delay == 0);
        @(negedge clk);
        tx_en = 1;
        #1;
        for (int i = 0; i < total; i++) begin
            rdy = tx_ready;
            if (tx_underrun) ucnt++;
            @(posedge clk);
            #1;
            if (rdy) begin
                idx++;
                if (idx < 3) tx_data = dat[idx];
                else tx_valid = 0;
            end
            @(negedge clk);
            cap[i] = tx_bit;
            if (mode == 1 && i + 1 == delay) tx_cts = 1;
            #1;
        end
        tx_en = 0;
        bad_at = -1;
        for (int i = total - 1; i >= 0; i--)
            if (cap[i] !== bits[i]) bad_at = i;
        check(bad_at < 0, req, bad_at, -1);
        check(idx == 4, req, idx, 4);
        check(ucnt == 1, "R9 underrun count", ucnt, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        // R1 reset state
        check(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
        check(tx_bit == 1, "R1 tx_bit", tx_bit, 1);
        check(tx_ready == 0, "R1 tx_ready", tx_ready, 0);
        check(tx_underrun == 0, "R1 tx_underrun", tx_underrun, 0);

        // R2, R3, R7: pattern receive sweep over length and bit order
        for (int r = 0; r < 2; r++) begin
            rx_run(0, 1, 1'(r), 1 + r, "R2 eight-bit pattern rx");
            rx_run(0, 2, 1'(r), 3 + r, "R3 sixteen-bit pattern rx");
            rx_run(0, 3, 1'(r), 5 + r, "R3 length code 3 rx");
        end
        // R4 external strobe receive, pattern before it ignored
        rx_run(1, 2, 1'b0, 7, "R4 external rx");
        rx_run(1, 2, 1'b1, 8, "R7 external rx reversed");
        // R5 automatic receive; R6 zero-length pattern acts as automatic
        rx_run(2, 0, 1'b0, 9, "R5 auto rx");
        rx_run(3, 1, 1'b1, 10, "R5 auto alt rx");
        rx_run(0, 0, 1'b0, 11, "R6 zero-length rx");

        // R10: lock held (pattern value received as data), resync drops it
        do_reset();
        cfg_mode = 2'd0; cfg_len = 2'd1; cfg_rev = 1'b0;
        nb = 0;
        push_const(1'b0, 4);
        push_pattern(1, 1'b0);
        push_byte(PAT[7:0], 1'b0);
        push_byte(8'h3C, 1'b0);
        begin
            int rs;
            rs = nb;
            push_const(1'b0, 1);
            push_byte(8'h00, 1'b0);
            push_pattern(1, 1'b0);
            push_byte(8'hE7, 1'b0);
            push_const(1'b0, 2);
            drive_rx(-1, rs);
        end
        check(gcnt == 3, "R10 byte count", gcnt, 3);
        check(got[0] == PAT[7:0], "R10 pattern as data", got[0], PAT[7:0]);
        check(got[1] == 8'h3C, "R10 second byte", got[1], 8'h3C);
        check(got[2] == 8'hE7, "R10 relock byte", got[2], 8'hE7);

        // R11: hold while not ready, newer byte replaces
        do_reset();
        cfg_mode = 2'd2; cfg_len = 2'd0; cfg_rev = 1'b0;
        rx_ready = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); rx_en = 1; rx_bit = 8'h5A >> (7 - i);
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 0) check(rx_valid == 1 && rx_byte == 8'h5A, "R11 first byte", rx_byte, 8'h5A);
            if (i == 4) check(rx_valid == 1 && rx_byte == 8'h5A, "R11 held byte", rx_byte, 8'h5A);
            rx_bit = 8'hC3 >> (7 - i);
        end
        @(negedge clk);
        check(rx_valid == 1 && rx_byte == 8'hC3, "R11 replaced byte", rx_byte, 8'hC3);
        rx_ready = 1; rx_bit = 0;
        @(negedge clk);
        check(rx_valid == 0, "R11 accepted", rx_valid, 0);
        rx_en = 0;

        // R8, R7, R9: pattern transmit sweep
        for (int r = 0; r < 2; r++) begin
            tx_run(0, 1, 1'(r), 0, 20 + r, "R8 eight-bit pattern tx");
            tx_run(0, 2, 1'(r), 0, 22 + r, "R8 sixteen-bit pattern tx");
        end
        // R4 external transmit waits for clear-to-send
        tx_run(1, 2, 1'b0, 0, 30, "R4 external tx immediate");
        tx_run(1, 2, 1'b0, 5, 31, "R4 external tx after wait");
        tx_run(1, 1, 1'b1, 11, 32, "R7 external tx reversed");
        // R5 automatic transmit; R6 zero-length pattern
        tx_run(2, 2, 1'b0, 0, 40, "R5 auto tx");
        tx_run(0, 0, 1'b1, 0, 41, "R6 zero-length tx");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule